// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that counts down from a software-chosen 32-bit reload value, one step per clock-enable pulse. The first time the count runs out, it raises an interrupt and starts over from the reload value. If the interrupt is still pending when the count runs out again, and the reset enable is set, it drives a system reset output. That output stays high until the synchronous system reset is applied.

Software keeps the system alive in one of two ways. It can rewrite the reload register, which restarts the count at once. It can also write to the interrupt-clear register, which drops the pending interrupt and restarts the count. A key-guarded lock register protects every other register from stray writes. Raw and masked interrupt status can be read separately, and the live counter value can be read back at any time.

The register bus is a single-cycle select/write strobe with a 12-bit byte address. Read data is combinational from the address whenever the bus is selected.

Top module: `dual_expiry_watchdog`

## Requirements
- R1: After the synchronous reset, the reload register and the counter both hold 0xFFFFFFFF. Control, raw status, masked status, the interrupt output and the reset output are all 0, and the lock register reads 0 (unlocked).
- R2: Register offsets are: reload 0x000, counter value 0x004, control 0x008, interrupt clear 0x00C, raw status 0x010, masked status 0x014, lock 0xC00. Reading any other address, or reading with the bus deselected, returns 0.
- R3: While control bit 0 is set, each tick pulse lowers the counter by one, and reading 0x004 returns the live count. With bit 0 clear or no tick, the counter holds.
- R4: A tick arriving while the counter is 0 and control bit 0 is set sets raw status bit 0 and reloads the counter from the reload register.
- R5: If raw status is already set when such an expiry occurs and control bit 1 is set, the reset output goes high and stays high until the system reset. With bit 1 clear, no reset is produced.
- R6: An accepted write to 0x000 sets the reload register and the counter to the written value on the same edge.
- R7: An accepted write of any data to 0x00C clears raw status and reloads the counter from the reload register.
- R8: The interrupt output and masked status bit 0 both equal raw status AND control bit 0. Raw status bit 0 shows the interrupt before masking.
- R9: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. The lock register reads 1 when locked. While locked, writes to 0x000, 0x008 and 0x00C are ignored.
- R10: An accepted write to 0x000 or 0x00C on the same edge as a tick overrides that tick. No expiry is counted, so neither the interrupt nor the reset can be raised on that edge.
- R11: Writing 0 to control stops the count and masks the interrupt, while raw status keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| tickEn | input | 1 | Count-enable pulse |
| busSel | input | 1 | Bus select |
| busWr | input | 1 | Write strobe (with busSel) |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irqOut | output | 1 | Masked interrupt |
| resetOut | output | 1 | Sticky system reset request |

## Verification
The key collision is a keep-alive write (reload or interrupt clear) landing on the same edge as an expiring tick. When the interrupt is already pending, that expiry would otherwise assert the reset. The bench sets up both a first and a second expiry with a small reload value, then issues the write together with the tick in the critical cycle. It then checks that the reset output stays low, that raw status matches the write's effect, and that the counter reloaded. Random runs with reload values of 0 to 5 and random ticks produce these collisions often, and a bench-side model of the requirements judges each one.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 12;
  parameter int CTRL_W = 2;

  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
  localparam logic [DATA_W-1:0] LOAD_RST   = '1;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic              loadWr;
    logic              clrWr;
    logic              tickGo;
    logic              rstEn;
    logic [DATA_W-1:0] wdata;
  } dxw_strobe_t;
endpackage

// File: rtl/dxw_ctrl.sv
module dxw_ctrl
  import dxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              rawIrq,
  output dxw_strobe_t       strobe,
  output logic              irqOut,
  output logic [DATA_W-1:0] busRdata
);
  logic              lockedQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              anyWr, wrOk, lockHit;

  assign anyWr   = busSel && busWr;
  assign lockHit = anyWr && (busAddr == OFS_LOCK);
  assign wrOk    = anyWr && !lockedQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      lockedQ <= 1'b0;
      ctrlQ   <= '0;
    end else begin
      if (lockHit) lockedQ <= (busWdata != UNLOCK_KEY);
      if (wrOk && busAddr == OFS_CTRL) ctrlQ <= busWdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    strobe.loadWr = wrOk && (busAddr == OFS_LOAD);
    strobe.clrWr  = wrOk && (busAddr == OFS_CLR);
    strobe.tickGo = tickEn && ctrlQ[0];
    strobe.rstEn  = ctrlQ[1];
    strobe.wdata  = busWdata;
  end

  assign irqOut = rawIrq && ctrlQ[0];

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      case (busAddr)
        OFS_LOAD:  busRdata = loadVal;
        OFS_VALUE: busRdata = cntVal;
        OFS_CTRL:  busRdata = DATA_W'(ctrlQ);
        OFS_RAW:   busRdata = DATA_W'(rawIrq);
        OFS_MASK:  busRdata = DATA_W'(irqOut);
        OFS_LOCK:  busRdata = DATA_W'(lockedQ);
        default:   busRdata = '0;
      endcase
    end
  end

  // R9: a locked block keeps its control setting
  p_locked_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    (lockedQ && anyWr && busAddr == OFS_CTRL) |=> $stable(ctrlQ));
  // R9: key write leaves the block unlocked
  p_key_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
    (lockHit && busWdata == UNLOCK_KEY) |=> !lockedQ);
endmodule

// File: rtl/dxw_datapath.sv
module dxw_datapath
  import dxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dxw_strobe_t       strobe,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              rawIrq,
  output logic              resetOut
);
  logic [DATA_W-1:0] loadQ, cntQ;
  logic              rawQ, rstQ, atZero;

  assign atZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      loadQ <= LOAD_RST;
      cntQ  <= LOAD_RST;
      rawQ  <= 1'b0;
      rstQ  <= 1'b0;
    end else if (strobe.loadWr) begin
      loadQ <= strobe.wdata;
      cntQ  <= strobe.wdata;
    end else if (strobe.clrWr) begin
      rawQ <= 1'b0;
      cntQ <= loadQ;
    end else if (strobe.tickGo) begin
      if (atZero) begin
        cntQ <= loadQ;
        rawQ <= 1'b1;
        if (rawQ && strobe.rstEn) rstQ <= 1'b1;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign loadVal  = loadQ;
  assign cntVal   = cntQ;
  assign rawIrq   = rawQ;
  assign resetOut = rstQ;

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tickGo && !atZero && !strobe.loadWr && !strobe.clrWr)
      |=> cntQ == $past(cntQ) - 1'b1);
  p_expiry_sets_raw_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.tickGo && atZero && !strobe.loadWr && !strobe.clrWr) |=> rawQ);
  p_reset_needs_pending_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rstQ) |-> ($past(rawQ) && $past(strobe.rstEn)));
  p_reset_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    rstQ |=> rstQ);
  p_load_reload_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.loadWr |=> (cntQ == $past(strobe.wdata) && loadQ == $past(strobe.wdata)));
  p_clear_drops_raw_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrWr && !strobe.loadWr) |=> !rawQ);
  p_service_beats_expiry_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadWr || strobe.clrWr) |=> !$rose(rstQ));
endmodule

// File: rtl/dual_expiry_watchdog.sv
module dual_expiry_watchdog
  import dxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              resetOut
);
  dxw_strobe_t       strobe;
  logic [DATA_W-1:0] loadVal, cntVal;
  logic              rawIrq;

  dxw_ctrl i_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .loadVal(loadVal), .cntVal(cntVal),
    .rawIrq(rawIrq), .strobe(strobe), .irqOut(irqOut), .busRdata(busRdata)
  );

  dxw_datapath i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .loadVal(loadVal), .cntVal(cntVal),
    .rawIrq(rawIrq), .resetOut(resetOut)
  );
endmodule

// File: tb/test_dual_expiry_watchdog.sv
module test_dual_expiry_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, resetOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  // Reference state
  logic [31:0] mLoad, mCnt;
  logic [1:0]  mCtrl;
  logic        mRaw, mRst, mLocked;

  always #2 clk = ~clk;

  dual_expiry_watchdog i_dual_expiry_watchdog (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .resetOut(resetOut)
  );

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      A_LOAD: return mLoad;
      A_VAL:  return mCnt;
      A_CTRL: return {30'd0, mCtrl};
      A_RAW:  return {31'd0, mRaw};
      A_MASK: return {31'd0, mRaw & mCtrl[0]};
      A_LOCK: return {31'd0, mLocked};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    case (a)
      A_LOAD: return "R6";
      A_VAL:  return "R3";
      A_CTRL: return "R11";
      A_RAW:  return "R4";
      A_MASK: return "R8";
      A_LOCK: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic modelReset();
    mLoad = '1; mCnt = '1; mCtrl = 2'b00; mRaw = 0; mRst = 0; mLocked = 0;
  endtask

  task automatic modelStep(input logic s, input logic w, input logic [11:0] a,
                           input logic [31:0] d, input logic t);
    logic ok, serviced;
    logic [1:0] oldCtrl;
    oldCtrl  = mCtrl;
    ok       = s && w && !mLocked;
    serviced = ok && (a == A_LOAD || a == A_CLR);
    if (s && w && a == A_LOCK) mLocked = (d != KEY);
    if (ok && a == A_LOAD) begin mLoad = d; mCnt = d; end
    if (ok && a == A_CLR)  begin mRaw = 0; mCnt = mLoad; end
    if (ok && a == A_CTRL) mCtrl = d[1:0];
    if (!serviced && t && oldCtrl[0]) begin
      if (mCnt == 0) begin
        if (mRaw && oldCtrl[1]) mRst = 1;
        mRaw = 1;
        mCnt = mLoad;
      end else begin
        mCnt = mCnt - 1;
      end
    end
  endtask

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic s, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic t, input string tag);
    @(negedge clk);
    busSel = s; busWr = w; busAddr = a; busWdata = d; tickEn = t;
    #1;
    if (s && !w) check32(tag, busRdata, modelRead(a));
    check32("R8 irqOut", {31'd0, irqOut}, {31'd0, mRaw & mCtrl[0]});
    check32("R5 resetOut", {31'd0, resetOut}, {31'd0, mRst});
    @(posedge clk);
    modelStep(s, w, a, d, t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic t);
    busOp(1, 1, a, d, t, "wr");
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    busOp(1, 0, a, 32'd0, 0, tag);
  endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) busOp(0, 0, 12'h0, 32'd0, 1, "tick");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; busSel = 0; busWr = 0; tickEn = 0;
    @(posedge clk); @(posedge clk);
    modelReset();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();
    // R1: reset state with explicit expected values
    rd(A_LOAD, "R1"); check32("R1 load", busRdata, 32'hFFFFFFFF);
    rd(A_VAL,  "R1"); check32("R1 value", busRdata, 32'hFFFFFFFF);
    rd(A_CTRL, "R1"); check32("R1 ctrl", busRdata, 32'd0);
    rd(A_RAW,  "R1"); rd(A_MASK, "R1"); rd(A_LOCK, "R1");
    // R2: unmapped and deselected reads
    rd(12'h020, "R2"); check32("R2 unmapped", busRdata, 32'd0);
    busOp(0, 0, A_LOAD, 0, 0, "R2");
    check32("R2 deselected", busRdata, 32'd0);

    // R3/R4/R6: count down, first expiry
    wr(A_LOAD, 32'd2, 0); rd(A_VAL, "R6");
    wr(A_CTRL, 32'd3, 0);
    tick(1); rd(A_VAL, "R3"); check32("R3 value", busRdata, 32'd1);
    tick(2); rd(A_RAW, "R4"); check32("R4 raw", busRdata, 32'd1);
    rd(A_VAL, "R4"); check32("R4 reload", busRdata, 32'd2);
    rd(A_MASK, "R8");
    // R10: clear on the second expiring tick wins
    tick(2); wr(A_CLR, 32'd0, 1);
    rd(A_RAW, "R10"); check32("R10 raw", busRdata, 32'd0);
    check32("R10 reset", {31'd0, resetOut}, 32'd0);
    // R10: load write on second expiring tick
    tick(3); tick(2); wr(A_LOAD, 32'd4, 1);
    rd(A_VAL, "R10"); check32("R10 value", busRdata, 32'd4);
    check32("R10 no reset", {31'd0, resetOut}, 32'd0);
    // R5: unserviced second expiry asserts reset, sticky
    tick(5); rd(A_VAL, "R5"); tick(1);
    check32("R5 asserted", {31'd0, resetOut}, 32'd1);
    wr(A_CLR, 0, 0); wr(A_CTRL, 0, 0); tick(3);
    check32("R5 sticky", {31'd0, resetOut}, 32'd1);
    doReset();
    check32("R5 cleared by rst", {31'd0, resetOut}, 32'd0);
    // R5: reset enable clear -> no reset
    wr(A_LOAD, 32'd1, 0); wr(A_CTRL, 32'd1, 0); tick(8);
    check32("R5 disabled", {31'd0, resetOut}, 32'd0);
    // R11: stop, raw retained, irq masked
    wr(A_CTRL, 32'd0, 0); rd(A_RAW, "R11"); rd(A_MASK, "R11");
    check32("R11 irq masked", {31'd0, irqOut}, 32'd0);
    rd(A_VAL, "R11"); tick(3); rd(A_VAL, "R11");
    // R9: lock
    wr(A_LOCK, 32'd1, 0); rd(A_LOCK, "R9"); check32("R9 locked", busRdata, 32'd1);
    wr(A_LOAD, 32'd77, 0); rd(A_LOAD, "R9");
    wr(A_CTRL, 32'd3, 0); rd(A_CTRL, "R9"); wr(A_CLR, 0, 0); rd(A_RAW, "R9");
    check32("R9 raw kept", busRdata, 32'd1);
    wr(A_LOCK, KEY, 0); rd(A_LOCK, "R9"); check32("R9 unlocked", busRdata, 32'd0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [11:0] a;
      logic t;
      op = $urandom % 32;
      t  = 1'($urandom % 2);
      if (mRst && ($urandom % 8 == 0)) doReset();
      else if (op < 5)  wr(A_LOAD, $urandom % 6, t);
      else if (op < 8)  wr(A_CLR, $urandom, t);
      else if (op < 10) wr(A_CTRL, $urandom % 4, t);
      else if (op < 12) wr(A_LOCK, KEY, t);
      else if (op < 13) wr(A_LOCK, $urandom % 3, t);
      else if (op < 20) busOp(0, 0, 12'h0, 0, t, "tick");
      else begin
        case ($urandom % 8)
          0: a = A_LOAD; 1: a = A_VAL; 2: a = A_CTRL; 3: a = A_RAW;
          4: a = A_MASK; 5: a = A_LOCK; 6: a = A_CLR; default: a = 12'h018;
        endcase
        busOp(1, 0, a, 0, t, tagFor(a));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule